// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps, for each of four DMA channels, a base address, a base count, a current address and a current count. Software reaches all of them through an 8-bit port. A byte-pointer flip-flop is shared by every channel and decides whether an access hits the low or the high byte. Each byte access uses the pointer's present state and then inverts it, so a 16-bit value always moves as a low byte followed by a high byte. Index bit 0 chooses between the address register and the count register. The index bits above it choose the channel.

The current count starts at zero and counts upward. When the high byte of a base register is written, the current address is reloaded from the base address and the current count goes back to zero. A read does not return the raw registers. A count read returns the remaining count, which is the base count minus the current count. An address read returns the current address moved by the current count, up or down according to the channel's direction. A transfer engine reports progress as a new current count in bytes. When that count reaches base count plus one, the block pulses a terminal-count flag for the channel, unless the channel is in cascade mode.

The `WIDE` parameter selects the word-wide controller variant. That variant decodes registers at double spacing and scales counts between words and bytes.

Top module: `dma_chan_regs`

## Requirements
- R1: The register index is `acc_addr[3:0]`, or `acc_addr[4:1]` when `WIDE` is 1. Index bits [2:1] select the channel. Index bit 0 selects the count register (1) or the address register (0). A byte access whose index bit 3 is set belongs to another block and has no effect here, including on the byte pointer.
- R2: The byte pointer is low (0) after reset. Every byte-wide read or write uses the present pointer state, which selects the low byte when 0 and the high byte when 1, and then inverts it at the clock edge. `ptr_high` shows the pointer state.
- R3: A high-byte write to a base register loads the current address from the base address, including the new byte, and clears the current count to zero. This takes priority over a progress update to the same channel in the same cycle. A low-byte write changes only the base register.
- R4: A count read returns the base count minus the current count, modulo 2^16.
- R5: An address read returns the current address plus the current count when the channel's `mode_dec` bit is 0, and minus the current count when it is 1, modulo 2^16.
- R6: A progress update (`prog_valid`) sets the current count of `prog_chan` to `prog_bytes` shifted right by 1 when `WIDE` is 1, or unshifted otherwise. `eng_start` gives that channel's current count and `eng_end` gives its base count plus one, both shifted left by the same amount.
- R7: `tc_pulse[ch]` is high for exactly one cycle, in the cycle after a progress update that makes the current count equal to base count plus one. It stays low when `mode_cascade[ch]` is set.
- R8: `ptr_clear` forces the byte pointer low at the next edge, overriding any toggle.
- R9: An access with `acc_byte` low changes no register and leaves the byte pointer as it was.
- R10: Reset clears the byte pointer and `tc_pulse` and leaves the base and current address and count registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | Access is byte-wide; other accesses are ignored |
| acc_addr | input | 5 | Port address |
| acc_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid in the access cycle |
| ptr_clear | input | 1 | Return the byte pointer to the low-byte state |
| ptr_high | output | 1 | Byte pointer state |
| mode_dec | input | 4 | Per-channel decrement direction |
| mode_cascade | input | 4 | Per-channel cascade mode |
| prog_valid | input | 1 | Progress update strobe |
| prog_chan | input | 2 | Channel being served |
| prog_bytes | input | 18 | New current count in bytes |
| eng_start | output | 18 | Current count of `prog_chan`, in bytes |
| eng_end | output | 18 | Base count plus one of `prog_chan`, in bytes |
| tc_pulse | output | 4 | Per-channel terminal-count pulse |

## Verification
The state that is hardest to reach from the ports is a register read back while the byte pointer is not where a simple low-then-high sequence leaves it. Examples are a skipped non-byte access in the middle of a pair, a lone low-byte write followed by a pointer clear, and a reset with the pointer high. The directed tests first leave the pointer high on purpose by making a single read, then apply the disturbing event. They then prove from the returned bytes both the pointer state and that the reload of R3 did not happen. Wrap of the adjusted address past 0xFFFF, the decrement direction and terminal count in cascade mode are reached by feeding chosen progress counts.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH  = 4,
  parameter int AW   = 16,
  parameter bit WIDE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic                 acc_byte,
  input  logic [4:0]           acc_addr,
  input  logic [7:0]           acc_wdata,
  output logic [7:0]           rd_data,
  input  logic                 ptr_clear,
  output logic                 ptr_high,
  input  logic [NCH-1:0]       mode_dec,
  input  logic [NCH-1:0]       mode_cascade,
  input  logic                 prog_valid,
  input  logic [$clog2(NCH)-1:0] prog_chan,
  input  logic [AW+1:0]        prog_bytes,
  output logic [AW+1:0]        eng_start,
  output logic [AW+1:0]        eng_end,
  output logic [NCH-1:0]       tc_pulse
);
  localparam int CHW = $clog2(NCH);
  localparam int IW  = CHW + 2;
  localparam int CW  = AW + 1;
  localparam int EW  = AW + 2;
  localparam int SH  = WIDE ? 1 : 0;

  logic [IW-1:0]  idx;
  logic           hit, wr, rd, sel_cnt;
  logic [CHW-1:0] sel_ch;
  logic [CW-1:0]  new_cnt;

  assign idx     = WIDE ? acc_addr[IW:1] : acc_addr[IW-1:0];
  assign hit     = acc_valid & acc_byte & ~idx[IW-1];
  assign wr      = hit & acc_write;
  assign rd      = hit & ~acc_write;
  assign sel_ch  = idx[IW-2:1];
  assign sel_cnt = idx[0];
  assign new_cnt = CW'(prog_bytes >> SH);

  logic [NCH-1:0][AW-1:0] addr_view, cnt_view;
  logic [NCH-1:0][CW-1:0] cur_view, lim_view;
  logic [NCH-1:0]         tc_hit;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [AW-1:0] ba, bc, ca;
    logic [CW-1:0] cc;
    logic          wr_me, prog_me;

    assign wr_me   = wr && (sel_ch == CHW'(g));
    assign prog_me = prog_valid && (prog_chan == CHW'(g));

    always_ff @(posedge clk) begin
      if (wr_me) begin
        if (!ptr_high) begin
          if (sel_cnt) bc[7:0] <= acc_wdata;
          else         ba[7:0] <= acc_wdata;
        end else begin
          if (sel_cnt) begin
            bc[AW-1:8] <= acc_wdata[AW-9:0];
            ca         <= ba;
          end else begin
            ba[AW-1:8] <= acc_wdata[AW-9:0];
            ca         <= {acc_wdata[AW-9:0], ba[7:0]};
          end
          cc <= '0;
        end
      end else if (prog_me) begin
        cc <= new_cnt;
      end
    end

    assign addr_view[g] = mode_dec[g] ? ca - cc[AW-1:0] : ca + cc[AW-1:0];
    assign cnt_view[g]  = bc - cc[AW-1:0];
    assign cur_view[g]  = cc;
    assign lim_view[g]  = {1'b0, bc} + CW'(1);
    assign tc_hit[g]    = prog_me && !wr_me && (new_cnt == lim_view[g]) && !mode_cascade[g];
  end

  logic [AW-1:0] rd_val, rd_hi;
  assign rd_val  = sel_cnt ? cnt_view[sel_ch] : addr_view[sel_ch];
  assign rd_hi   = rd_val >> 8;
  assign rd_data = !rd ? 8'h00 : (ptr_high ? rd_hi[7:0] : rd_val[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)         ptr_high <= 1'b0;
    else if (ptr_clear) ptr_high <= 1'b0;
    else if (hit)       ptr_high <= ~ptr_high;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tc_pulse <= '0;
    else        tc_pulse <= tc_hit;
  end

  assign eng_start = EW'(cur_view[prog_chan]) << SH;
  assign eng_end   = EW'(lim_view[prog_chan]) << SH;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH  = 4,
  parameter bit WIDE = 1'b0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic                   acc_byte,
  input logic [4:0]             acc_addr,
  input logic                   ptr_clear,
  input logic                   ptr_high,
  input logic [NCH-1:0]         mode_cascade,
  input logic                   prog_valid,
  input logic [$clog2(NCH)-1:0] prog_chan,
  input logic [NCH-1:0]         tc_pulse
);
  logic other_blk;
  assign other_blk = WIDE ? acc_addr[4] : acc_addr[3];

  assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_byte && !other_blk && !ptr_clear) |=> (ptr_high != $past(ptr_high)));

  assert_ctl_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && other_blk && !ptr_clear) |=> $stable(ptr_high));

  assert_ptr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clear |=> !ptr_high);

  assert_nonbyte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_byte && !ptr_clear) |=> $stable(ptr_high));

  assert_tc_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_pulse));

  assert_tc_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_pulse) |-> $past(prog_valid));

  assert_tc_cascade_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && mode_cascade[prog_chan]) |=> !(|tc_pulse));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .WIDE(WIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_byte(acc_byte),
  .acc_addr(acc_addr), .ptr_clear(ptr_clear), .ptr_high(ptr_high),
  .mode_cascade(mode_cascade), .prog_valid(prog_valid), .prog_chan(prog_chan),
  .tc_pulse(tc_pulse)
);

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        rst_n, acc_valid, acc_write, acc_byte, ptr_clear, prog_valid;
  logic [4:0]  acc_addr;
  logic [7:0]  acc_wdata, rd_data, rd_w;
  logic        ptr_high, ptr_w;
  logic [3:0]  mode_dec, mode_cascade, tc_pulse, tc_w;
  logic [1:0]  prog_chan;
  logic [17:0] prog_bytes, eng_start, eng_end, es_w, ee_w;

  int nchk = 0, nfail = 0;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_byte(acc_byte), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .ptr_clear(ptr_clear), .ptr_high(ptr_high),
    .mode_dec(mode_dec), .mode_cascade(mode_cascade), .prog_valid(prog_valid),
    .prog_chan(prog_chan), .prog_bytes(prog_bytes), .eng_start(eng_start),
    .eng_end(eng_end), .tc_pulse(tc_pulse));

  dma_chan_regs #(.WIDE(1'b1)) u_wide (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_byte(acc_byte), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_w), .ptr_clear(ptr_clear), .ptr_high(ptr_w),
    .mode_dec(mode_dec), .mode_cascade(mode_cascade), .prog_valid(prog_valid),
    .prog_chan(prog_chan), .prog_bytes(prog_bytes), .eng_start(es_w),
    .eng_end(ee_w), .tc_pulse(tc_w));

  // [23]=read, [20:16]=addr, [15:8]=write data, [7:0]=expected read byte
  localparam logic [23:0] VEC [16] = '{
    24'h00_34_00, 24'h00_12_00, 24'h01_0F_00, 24'h01_00_00,
    24'h80_00_34, 24'h80_00_12, 24'h81_00_0F, 24'h81_00_00,
    24'h06_FE_00, 24'h06_FF_00, 24'h07_01_00, 24'h07_01_00,
    24'h86_00_FE, 24'h86_00_FF, 24'h87_00_01, 24'h87_00_01
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input bit byt, input logic [4:0] a,
                     input logic [7:0] d, output logic [7:0] r, output logic [7:0] rw);
    acc_valid = 1; acc_write = w; acc_byte = byt; acc_addr = a; acc_wdata = d;
    #1 r = rd_data; rw = rd_w;
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0; acc_byte = 0;
  endtask

  task automatic rdb(input logic [4:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] r, rw;
    acc(0, 1, a, 8'h00, r, rw);
    chk(tag, r, exp);
  endtask

  task automatic rdw(input logic [4:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] r, rw;
    acc(0, 1, a, 8'h00, r, rw);
    chk(tag, rw, exp);
  endtask

  task automatic wrb(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] r, rw;
    acc(1, 1, a, d, r, rw);
  endtask

  task automatic prog(input logic [1:0] ch, input logic [17:0] b);
    prog_valid = 1; prog_chan = ch; prog_bytes = b;
    @(posedge clk); #1;
    prog_valid = 0;
  endtask

  initial begin
    #500000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] r, rw;
    rst_n = 0; acc_valid = 0; acc_write = 0; acc_byte = 0; acc_addr = 0;
    acc_wdata = 0; ptr_clear = 0; prog_valid = 0; prog_chan = 0; prog_bytes = 0;
    mode_dec = 0; mode_cascade = 0;
    repeat (2) @(posedge clk);
    #1;
    chk("R10 reset pointer", ptr_high, 0);
    chk("R10 reset tc", tc_pulse, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R1 R2 R3 R4 R5 vector walk
    for (int i = 0; i < 16; i++) begin
      acc(!VEC[i][23], 1, VEC[i][20:16], VEC[i][15:8], r, rw);
      if (VEC[i][23]) chk($sformatf("R1/R2/R3/R4 vector %0d", i), r, VEC[i][7:0]);
    end

    // R6 engine outputs then progress
    prog_valid = 1; prog_chan = 0; prog_bytes = 18'd5;
    #1;
    chk("R6 eng_start", eng_start, 0);
    chk("R6 eng_end", eng_end, 18'h10);
    @(posedge clk); #1; prog_valid = 0;
    chk("R7 no tc below limit", tc_pulse, 0);

    rdb(0, 8'h39, "R5 inc addr low");
    rdb(0, 8'h12, "R5 inc addr high");
    rdb(1, 8'h0A, "R4 remain low");
    rdb(1, 8'h00, "R4 remain high");

    mode_dec = 4'b0001;
    rdb(0, 8'h2F, "R5 dec addr low");
    rdb(0, 8'h12, "R5 dec addr high");
    mode_dec = 0;

    prog(3, 18'd3);
    rdb(6, 8'h01, "R5 wrap low");
    rdb(6, 8'h00, "R5 wrap high");
    rdb(7, 8'hFE, "R4 ch3 low");
    rdb(7, 8'h00, "R4 ch3 high");

    // R7 terminal count
    prog(0, 18'h10);
    chk("R7 tc pulse", tc_pulse, 4'b0001);
    @(posedge clk); #1;
    chk("R7 tc one cycle", tc_pulse, 0);
    mode_cascade = 4'b0001;
    prog(0, 18'h10);
    chk("R7 cascade no tc", tc_pulse, 0);
    mode_cascade = 0;
    prog(0, 18'h0F);
    chk("R7 no tc at base", tc_pulse, 0);

    // R9 non-byte access with pointer high
    rdb(1, 8'h00, "R4 remain zero");
    acc(1, 0, 5'd0, 8'h99, r, rw);
    chk("R9 pointer kept", ptr_high, 1);
    rdb(1, 8'h00, "R9 count high");
    rdb(0, 8'h43, "R9 no reload low");
    rdb(0, 8'h12, "R9 no reload high");

    // R3 low byte only, R8 pointer clear
    wrb(0, 8'h00);
    chk("R2 pointer after write", ptr_high, 1);
    ptr_clear = 1;
    @(posedge clk); #1; ptr_clear = 0;
    chk("R8 pointer cleared", ptr_high, 0);
    rdb(0, 8'h43, "R3 low write no reload");
    rdb(0, 8'h12, "R3 low write no reload high");
    wrb(0, 8'h00);
    wrb(0, 8'h20);
    rdb(0, 8'h00, "R3 reload low");
    rdb(0, 8'h20, "R3 reload high");
    rdb(1, 8'h0F, "R3 count cleared");
    rdb(1, 8'h00, "R3 count cleared high");

    // R10 reset keeps registers
    rdb(7, 8'hFE, "R10 pre-reset");
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1;
    chk("R10 pointer low", ptr_high, 0);
    chk("R10 tc low", tc_pulse, 0);
    rst_n = 1;
    rdb(7, 8'hFE, "R10 kept low");
    rdb(7, 8'h00, "R10 kept high");

    // R1 double-spaced decode, R6 scaling
    wrb(2, 8'h44);
    wrb(3, 8'h00);
    rdw(3, 8'h44, "R1 wide count low");
    rdw(2, 8'h00, "R1 wide count high");
    prog_valid = 1; prog_chan = 0; prog_bytes = 18'h0A;
    #1;
    chk("R6 wide eng_end", ee_w, 18'h8A);
    @(posedge clk); #1; prog_valid = 0;
    rdw(2, 8'h3F, "R6 wide remain");
    rdw(2, 8'h00, "R6 wide remain high");
    prog_valid = 1; prog_chan = 0; prog_bytes = 18'h8A;
    #1;
    chk("R6 wide eng_start", es_w, 18'h0A);
    @(posedge clk); #1; prog_valid = 0;
    chk("R7 wide tc", tc_w, 4'b0001);

    // R1 control region ignored
    rdb(8, 8'h00, "R1 control region data");
    chk("R1 control region pointer", ptr_high, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule